// File: doc/BRIEF.md
# Dual-Line Audio Serial Merger

This block accepts a serial PCM audio link in which the left and right samples arrive at the same time on two separate data lines. Both samples are carried during the half-frame in which word select is high. The block turns that into one interleaved data line with a matching word-select output, so that a downstream transmitter that expects a single right-justified line can use it. The block's clock is the serial bit clock itself. Input lines are sampled on its rising edge and the outputs are registered on its falling edge, so a receiver that samples on the rising edge sees settled values.

Each frame lasts 64 bit clocks, which gives two word-select halves of 32 bits. Each 18-bit sample sits in the last 18 bits of a half, MSB first. The right line is held back by one half-frame, so that its sample lands in the half where the output word select is low. The word select is held back by six bit clocks, so that every 18-bit sample becomes a 24-bit right-justified word whose six low bits are zero. All bit positions outside the sample window are driven low, whatever the input lines carry there.

Top module: `dual_line_merger`

## Requirements
- R1: While the output word select is high, an output bit that falls in the sample window equals the left-line bit captured on the rising edge just before that output changed.
- R2: While the output word select is low, an output bit that falls in the sample window equals the right-line bit captured 32 bit clocks earlier.
- R3: Outside reset and warm-up, the output word select equals the input word select captured 6 bit clocks earlier (polarity kept: 1 = left, 0 = right).
- R4: An output half holds 32 bits. Counting the output bit position q from 0 at each output word-select change, bits q = 0..7 and q = 26..31 are 0. So the 18-bit sample occupies q = 8..25, which makes the 24-bit word {sample, 6'b0}.
- R5: The reset is synchronous and active high. While it is held, both outputs are 0.
- R6: After reset is released, both outputs stay 0 until 64 rising edges have passed. The output at the falling edge after the 64th rising edge is the first live value.
- R7: Framing is taken from word-select changes, so the block locks correctly whatever the half-frame phase is at reset release.
- R8: Left-line content during input word select low, right-line content during input word select low, and both lines in the 14 leading bits of the high half have no effect on the output.
- R9: Outputs change only on the falling edge of the clock. They are stable from one falling edge through the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock (64 per frame) |
| rst | input | 1 | Synchronous active-high reset |
| ws_i | input | 1 | Input word select, 1 = left half |
| l_i | input | 1 | Left-channel serial data |
| r_i | input | 1 | Right-channel serial data, same half as left |
| sd_o | output | 1 | Merged interleaved serial data |
| ws_o | output | 1 | Realigned word select for the merged line |

## Verification
A set of sample pairs is streamed frame by frame. The pairs are all ones against all zeros, single MSB or LSB set, alternating bit patterns, and a mixed value, so that a swapped channel, a lost MSB or LSB, or a one-bit misalignment each produces a distinct wrong 24-bit word. Random data fills every ignored slot of both input lines, which separates correct pad zeroing and half-frame gating from designs that simply pass the line through. A second reset is released at a half-frame phase offset, to show that framing comes from word-select changes and not from reset timing. The outputs are also checked through the whole warm-up window.

// File: rtl/merger_pkg.sv
package merger_pkg;
  typedef struct packed {
    logic ws;
    logic left;
    logic right;
  } lane_t;
endpackage

// File: rtl/mrg_capture.sv
module mrg_capture
  import merger_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ws_i,
  input  logic  l_i,
  input  logic  r_i,
  output lane_t q
);
  // rising-edge capture of the incoming lines
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= '{ws: ws_i, left: l_i, right: r_i};
  end
endmodule

// File: rtl/mrg_delay.sv
module mrg_delay #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/mrg_tracker.sv
module mrg_tracker #(
  parameter int HALF_BITS = 32,
  parameter int POS_W     = $clog2(HALF_BITS),
  parameter int FRAME     = 2 * HALF_BITS,
  parameter int CNT_W     = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  output logic [POS_W-1:0] pos,
  output logic             warm
);
  logic             ws_p;
  logic [POS_W-1:0] pos_r;
  logic [CNT_W-1:0] cnt;

  // bit position within the current half, restarted on any select change
  assign pos  = (ws != ws_p) ? '0 : pos_r + 1'b1;
  assign warm = (cnt == CNT_W'(FRAME));

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_p  <= 1'b0;
      pos_r <= '0;
      cnt   <= '0;
    end else begin
      ws_p  <= ws;
      pos_r <= pos;
      if (!warm) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dual_line_merger.sv
module dual_line_merger #(
  parameter int HALF_BITS = 32,
  parameter int IN_BITS   = 18,
  parameter int OUT_BITS  = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic ws_i,
  input  logic l_i,
  input  logic r_i,
  output logic sd_o,
  output logic ws_o
);
  import merger_pkg::*;

  localparam int PAD   = OUT_BITS - IN_BITS;
  localparam int LEAD  = HALF_BITS - IN_BITS;
  localparam int POS_W = $clog2(HALF_BITS);

  lane_t            cap;
  logic             r_late;
  logic             ws_late;
  logic [POS_W-1:0] pos;
  logic             warm;
  logic             in_win;
  logic             bit_nxt;
  logic             ws_nxt;

  mrg_capture u_cap (
    .clk  (clk),
    .rst  (rst),
    .ws_i (ws_i),
    .l_i  (l_i),
    .r_i  (r_i),
    .q    (cap)
  );

  // right line held back one half-frame
  mrg_delay #(.DEPTH(HALF_BITS)) u_rdly (
    .clk (clk),
    .rst (rst),
    .d   (cap.right),
    .q   (r_late)
  );

  // select held back by the pad width
  mrg_delay #(.DEPTH(PAD)) u_wdly (
    .clk (clk),
    .rst (rst),
    .d   (cap.ws),
    .q   (ws_late)
  );

  mrg_tracker #(.HALF_BITS(HALF_BITS)) u_trk (
    .clk  (clk),
    .rst  (rst),
    .ws   (cap.ws),
    .pos  (pos),
    .warm (warm)
  );

  assign in_win  = (pos >= POS_W'(LEAD));
  assign bit_nxt = warm && in_win && (ws_late ? cap.left : r_late);
  assign ws_nxt  = warm && ws_late;

  // launch on the falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      sd_o <= 1'b0;
      ws_o <= 1'b0;
    end else begin
      sd_o <= bit_nxt;
      ws_o <= ws_nxt;
    end
  end
endmodule

// File: rtl/mrg_checker.sv
module mrg_checker #(
  parameter int HALF_BITS = 32,
  parameter int IN_BITS   = 18,
  parameter int OUT_BITS  = 24
) (
  input logic clk,
  input logic rst,
  input logic ws_i,
  input logic l_i,
  input logic sd_o,
  input logic ws_o
);
  localparam int FRAME = 2 * HALF_BITS;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int POS_W = $clog2(HALF_BITS);
  localparam int Q_LO  = HALF_BITS - OUT_BITS;
  localparam int Q_HI  = Q_LO + IN_BITS;

  logic [CNT_W-1:0] ck;
  logic             wsp;
  logic [POS_W-1:0] q_r;
  logic [POS_W-1:0] q_cur;
  logic [1:0]       edges;
  logic             live;
  logic             locked;

  assign live   = (ck == CNT_W'(FRAME));
  assign q_cur  = (ws_o != wsp) ? '0 : q_r + 1'b1;
  assign locked = live && (edges == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck    <= '0;
      wsp   <= 1'b0;
      q_r   <= '0;
      edges <= '0;
    end else begin
      if (!live) ck <= ck + 1'b1;
      wsp <= ws_o;
      q_r <= q_cur;
      if (live && (ws_o != wsp) && edges != 2'd2) edges <= edges + 1'b1;
    end
  end

  // R6
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !live |-> (!sd_o && !ws_o));

  // R3
  ws_delay_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> (ws_o == $past(ws_i, 7)));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && (q_cur < POS_W'(Q_LO) || q_cur >= POS_W'(Q_HI))) |-> !sd_o);

  // R1
  left_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && ws_o && q_cur >= POS_W'(Q_LO) && q_cur < POS_W'(Q_HI))
      |-> (sd_o == $past(l_i)));
endmodule

bind dual_line_merger mrg_checker #(
  .HALF_BITS (HALF_BITS),
  .IN_BITS   (IN_BITS),
  .OUT_BITS  (OUT_BITS)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .ws_i (ws_i),
  .l_i  (l_i),
  .sd_o (sd_o),
  .ws_o (ws_o)
);

// File: tb/sim_dual_line_merger.sv
module sim_dual_line_merger;
  localparam int RING = 4096;

  // {left18, right18, expected left word24, expected right word24}
  localparam logic [83:0] VEC [6] = '{
    {18'h3FFFF, 18'h00000, 24'hFFFFC0, 24'h000000},
    {18'h00001, 18'h20000, 24'h000040, 24'h800000},
    {18'h2AAAA, 18'h15555, 24'hAAAA80, 24'h555540},
    {18'h12345, 18'h3FFFF, 24'h48D140, 24'hFFFFC0},
    {18'h20000, 18'h00001, 24'h800000, 24'h000040},
    {18'h00000, 18'h2AAAA, 24'h000000, 24'hAAAA80}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws_i = 1'b0, l_i = 1'b0, r_i = 1'b0;
  logic sd_o, ws_o;

  always #4 clk = ~clk;

  dual_line_merger u0 (
    .clk(clk), .rst(rst), .ws_i(ws_i), .l_i(l_i), .r_i(r_i),
    .sd_o(sd_o), .ws_o(ws_o)
  );

  int ntests = 0, nfail = 0;
  bit ws_a [RING], l_a [RING], r_a [RING], rs_a [RING];
  int hp_a [RING], fr_a [RING];
  int n = 0, j0 = 0, tg = 0, off = 0;
  string tag = "";
  logic [23:0] acc = '0;
  logic [1:0] last = '0;
  bit r9_on = 0;
  bit done = 0;

  task automatic note(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s%s actual=%0h expected=%0h (index %0d)", tag, req, act, exp, n - 1);
    end
  endtask

  task automatic check(input int j);
    int k = j % RING;
    bit wx, dx;
    if (rs_a[k]) begin
      note(sd_o == 0 && ws_o == 0, "R5 reset outputs", {sd_o, ws_o}, 0);
    end else if (j < j0 + 63) begin
      note(sd_o == 0 && ws_o == 0, "R6 warm-up outputs", {sd_o, ws_o}, 0);
    end else begin
      wx = ws_a[(j - 6) % RING];
      note(ws_o == wx, "R3 word select", ws_o, wx);
      if (hp_a[k] < 14) dx = 0;
      else dx = wx ? l_a[k] : r_a[(j - 32) % RING];
      if (hp_a[k] < 14)
        note(sd_o == dx, "R4 R8 pad/ignored bit", sd_o, dx);
      else if (wx)
        note(sd_o == dx, "R1 left bit", sd_o, dx);
      else
        note(sd_o == dx, "R2 right bit", sd_o, dx);
      acc = {acc[22:0], sd_o};
      if (hp_a[k] == 5 && j >= j0 + 63 + 24) begin
        logic [83:0] v = VEC[fr_a[(j - 6) % RING] % 6];
        logic [23:0] ew = wx ? v[47:24] : v[23:0];
        note(acc == ew, wx ? "R1 R4 left word" : "R2 R4 right word", acc, ew);
      end
    end
  endtask

  task automatic step(input bit rv);
    int k = n % RING;
    int ph, hp, half, fr;
    logic [83:0] v;
    @(negedge clk); #1;
    if (n > 0) check(n - 1);
    last = {sd_o, ws_o};
    ph = tg + off;
    hp = ph % 32;
    half = (ph / 32) % 2;
    fr = ph / 64;
    v = VEC[fr % 6];
    ws_i = (half == 0);
    if (half == 0 && hp >= 14) begin
      l_i = v[83 - (hp - 14)];
      r_i = v[65 - (hp - 14)];
    end else begin
      l_i = 1'($urandom);
      r_i = 1'($urandom);
    end
    rst = rv;
    ws_a[k] = ws_i; l_a[k] = l_i; r_a[k] = r_i; rs_a[k] = rv;
    hp_a[k] = hp; fr_a[k] = fr;
    if (!rv && (n == 0 || rs_a[(n - 1) % RING])) j0 = n;
    n++;
    tg++;
  endtask

  // R9: nothing moves between a falling edge and the next rising edge
  always @(posedge clk) begin
    #2;
    if (r9_on && !done) note({sd_o, ws_o} == last, "R9 output stability", {sd_o, ws_o}, last);
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nfail++;
      ntests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    // reset held (R5)
    for (int i = 0; i < 6; i++) step(1'b1);
    r9_on = 1;
    // main vector walk, aligned phase
    tag = "";
    tg = 0; off = 0;
    for (int i = 0; i < 6 * 64 + 120; i++) step(1'b0);
    // reset mid-stream, release at offset phase (R7)
    for (int i = 0; i < 4; i++) step(1'b1);
    tag = "R7 ";
    tg = 0; off = 17;
    for (int i = 0; i < 6 * 64 + 120; i++) step(1'b0);
    // another phase: release during the low half
    for (int i = 0; i < 3; i++) step(1'b1);
    tg = 0; off = 45;
    for (int i = 0; i < 3 * 64 + 80; i++) step(1'b0);
    step(1'b0);
    r9_on = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule